// File: doc/BRIEF.md
# Memory word to pixel unpacker

This block sits between a memory read path and a video pixel stream. Each word it reads from external memory holds several whole pixels packed side by side. A pixel here means all colour planes of one sample, carried in one beat. The block hands the pixels out one per output beat. The lowest pixel in the word goes first, and each higher pixel follows in turn. No pixel is ever split across two words. Any bits above the last whole pixel are padding and are thrown away.

Before each frame, a one-cycle `frame_start` pulse loads the number of pixels the frame holds (width times height). The block then pulls words in arrival order and emits exactly that many pixels. It marks the final pixel with `out_last` and discards any pixels left over in the final word. After that it stays idle until the next pulse.

Both streams use valid/ready handshakes. A beat transfers on a rising edge where valid and ready are both high. When `out_ready` is low and `out_valid` is high, the output stalls: the pixel and its flags stay frozen until the beat is taken. The input stalls while a word is still being drained. In the cycle the last pixel of a word is taken, `in_ready` may rise so that the next word loads with no bubble. `in_ready` depends on `out_ready` within the same cycle.

Top module: `pix_unpack`

## Requirements
- R1: During and immediately after reset, `out_valid`, `out_last` and `in_ready` are low.
- R2: In the cycle after a `frame_start` pulse with a nonzero `frame_pixels`, `in_ready` is high and `out_valid` is low.
- R3: Pixel k of a word (k counted from 0) is bits [k*PIXEL_W +: PIXEL_W]. Pixel 0 is emitted first and k rises by one per output beat.
- R4: Each word yields floor(WORD_W/PIXEL_W) pixels, and its bits above that are ignored. A frame of N pixels consumes exactly ceil(N / that count) words. With the defaults (24-bit pixels, 64-bit words) this is two pixels per word.
- R5: Words are unpacked in the order they were accepted on the input.
- R6: While `out_valid` is high and `out_ready` is low, the next cycle still has `out_valid` high with `out_pixel` and `out_last` unchanged.
- R7: A word is accepted while another is still held only if the held word's last pixel is taken in that same cycle and that pixel is not the frame's last one.
- R8: `out_last` is high exactly on the N-th pixel of the frame. Once that pixel is taken, `out_valid` and `in_ready` stay low until the next `frame_start`, and unused pixels in the final word are dropped.
- R9: A `frame_start` pulse in the middle of a frame discards the held word and the remaining count. The next pixel comes from pixel 0 of the first word accepted afterwards.
- R10: A `frame_start` pulse with `frame_pixels` equal to 0 leaves the block idle, with `in_ready` and `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse that loads the frame pixel count and flushes held data |
| frame_pixels | input | CNT_W | Number of pixels in the frame, sampled on `frame_start` |
| in_valid | input | 1 | Memory word is presented |
| in_ready | output | 1 | Block accepts the presented word this cycle |
| in_word | input | WORD_W | Packed memory word |
| out_valid | output | 1 | Pixel is presented |
| out_ready | input | 1 | Downstream takes the pixel this cycle |
| out_pixel | output | PIXEL_W | Pixel with all colour planes side by side |
| out_last | output | 1 | Marks the final pixel of the frame |

## Verification
The bound checker checks these rules on every cycle:
- a stalled output stays frozen (R6);
- a word is never taken while a held word is still stalled (R7);
- the block goes quiet after the frame's last pixel (R8);
- the state after a flush or an empty frame is idle (R2, R10).

Other behaviour shows up only in the bench's scenarios. That covers the bit placement and order of the unpacked pixels, the number of words each frame consumes, the dropping of a half-used final word, and a restart in the middle of a frame. The bench compares these against a pixel sequence it computes from the words it sent.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;

  // Whole pixels that fit in one memory word; leftover bits are padding.
  function automatic int slots_per_word(input int word_w, input int pixel_w);
    return word_w / pixel_w;
  endfunction

  // Index width for a slot counter, never narrower than one bit.
  function automatic int slot_idx_w(input int slots);
    return (slots > 1) ? $clog2(slots) : 1;
  endfunction

endpackage

// File: rtl/unpack_slot_mux.sv
module unpack_slot_mux #(
  parameter int PIXEL_W = 24,
  parameter int WORD_W  = 64,
  parameter int SLOTS   = 2,
  parameter int IDX_W   = 1
) (
  input  logic [WORD_W-1:0]  word,
  input  logic [IDX_W-1:0]   idx,
  output logic [PIXEL_W-1:0] pixel
);

  logic [PIXEL_W-1:0] lane [SLOTS];

  for (genvar k = 0; k < SLOTS; k++) begin : g_lane
    assign lane[k] = word[k*PIXEL_W +: PIXEL_W];
  end

  always_comb begin
    pixel = '0;
    for (int k = 0; k < SLOTS; k++) begin
      if (idx == IDX_W'(k)) pixel = lane[k];
    end
  end

endmodule

// File: rtl/unpack_hold.sv
module unpack_hold #(
  parameter int WORD_W = 64,
  parameter int SLOTS  = 2,
  parameter int IDX_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  logic              advance,
  input  logic              drop,
  output logic [WORD_W-1:0] word_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic              full_q,
  output logic              at_last
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

  assign at_last = (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      idx_q  <= '0;
      full_q <= 1'b0;
    end else if (flush) begin
      full_q <= 1'b0;
      idx_q  <= '0;
    end else if (load) begin
      word_q <= word_in;
      idx_q  <= '0;
      full_q <= 1'b1;
    end else if (advance) begin
      if (at_last || drop) begin
        full_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/unpack_frame_cnt.sv
module unpack_frame_cnt #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             active,
  output logic             final_px
);

  logic [CNT_W-1:0] left_q;

  assign active   = (left_q != '0);
  assign final_px = (left_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (load) begin
      left_q <= load_val;
    end else if (dec && active) begin
      left_q <= left_q - 1'b1;
    end
  end

endmodule

// File: rtl/pix_unpack.sv
module pix_unpack #(
  parameter int PIXEL_W = 24,
  parameter int WORD_W  = 64,
  parameter int CNT_W   = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic [CNT_W-1:0]   frame_pixels,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WORD_W-1:0]  in_word,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [PIXEL_W-1:0] out_pixel,
  output logic               out_last
);

  import pix_unpack_pkg::*;

  localparam int SLOTS = slots_per_word(WORD_W, PIXEL_W);
  localparam int IDX_W = slot_idx_w(SLOTS);

  if (SLOTS < 1) begin : g_bad_size
    $error("pix_unpack: a word must hold at least one pixel");
  end

  logic [WORD_W-1:0] held_word;
  logic [IDX_W-1:0]  slot_idx;
  logic              held_full;
  logic              slot_last;
  logic              frm_active;
  logic              frm_final;
  logic              take_px;
  logic              take_word;

  assign out_valid = held_full && frm_active;
  assign out_last  = out_valid && frm_final;
  assign take_px   = out_valid && out_ready;

  // Refill when empty, or when the last slot leaves now and the frame goes on.
  assign in_ready  = frm_active && !frame_start &&
                     (!held_full || (out_ready && slot_last && !frm_final));
  assign take_word = in_valid && in_ready;

  unpack_frame_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (frame_start),
    .load_val (frame_pixels),
    .dec      (take_px),
    .active   (frm_active),
    .final_px (frm_final)
  );

  unpack_hold #(.WORD_W(WORD_W), .SLOTS(SLOTS), .IDX_W(IDX_W)) i_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (frame_start),
    .load    (take_word),
    .word_in (in_word),
    .advance (take_px),
    .drop    (frm_final),
    .word_q  (held_word),
    .idx_q   (slot_idx),
    .full_q  (held_full),
    .at_last (slot_last)
  );

  unpack_slot_mux #(.PIXEL_W(PIXEL_W), .WORD_W(WORD_W), .SLOTS(SLOTS), .IDX_W(IDX_W)) i_mux (
    .word  (held_word),
    .idx   (slot_idx),
    .pixel (out_pixel)
  );

endmodule

// File: rtl/pix_unpack_chk.sv
module pix_unpack_chk #(
  parameter int PIXEL_W = 24,
  parameter int CNT_W   = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_start,
  input logic [CNT_W-1:0]   frame_pixels,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [PIXEL_W-1:0] out_pixel,
  input logic               out_last
);

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !frame_start) |=>
      (out_valid && $stable(out_pixel) && $stable(out_last)));

  // R7
  accept_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && out_valid) |-> (out_ready && !out_last));

  // R8
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last && !frame_start) |=> (!out_valid && !in_ready));

  // R8
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R2
  restart_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && frame_pixels != '0) |=> !out_valid);

  // R10
  empty_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && frame_pixels == '0) |=> (!out_valid && !in_ready));

endmodule

bind pix_unpack pix_unpack_chk #(.PIXEL_W(PIXEL_W), .CNT_W(CNT_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_start  (frame_start),
  .frame_pixels (frame_pixels),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_pixel    (out_pixel),
  .out_last     (out_last)
);

// File: tb/test_pix_unpack.sv
`timescale 1ns/1ps
module test_pix_unpack;
  localparam int PIXEL_W = 24;
  localparam int WORD_W  = 64;
  localparam int CNT_W   = 24;
  localparam int PW      = WORD_W / PIXEL_W;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               frame_start;
  logic [CNT_W-1:0]   frame_pixels;
  logic               in_valid;
  logic               in_ready;
  logic [WORD_W-1:0]  in_word;
  logic               out_valid;
  logic               out_ready;
  logic [PIXEL_W-1:0] out_pixel;
  logic               out_last;

  int errors = 0;
  int checks = 0;
  logic [WORD_W-1:0] mem [0:127];

  always #5 clk = ~clk;

  pix_unpack #(.PIXEL_W(PIXEL_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) i_pix_unpack (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_pixels(frame_pixels),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel), .out_last(out_last)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [PIXEL_W-1:0] exp_pix(input int i);
    logic [WORD_W-1:0] w;
    w = mem[i / PW];
    return w[(i % PW) * PIXEL_W +: PIXEL_W];
  endfunction

  task automatic fill_mem();
    for (int k = 0; k < 128; k++) mem[k] = {$urandom, $urandom};
  endtask

  task automatic run_frame(input int n, input int pin, input int pout, input int abort_at);
    int pi;
    int wi;
    int cyc;
    bit prev_hold;
    logic [PIXEL_W-1:0] prev_pix;
    fill_mem();
    @(negedge clk);
    frame_start = 1'b1; frame_pixels = CNT_W'(n); in_valid = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    frame_start = 1'b0;
    #1;
    check(in_ready == (n > 0), "R2/R10 in_ready after start", 64'(in_ready), 64'(n > 0));
    check(!out_valid, "R2/R9 out_valid after start", 64'(out_valid), 64'd0);
    pi = 0; wi = 0; cyc = 0; prev_hold = 1'b0; prev_pix = '0;
    while (pi < n && cyc < 5000 && !(abort_at >= 0 && pi >= abort_at)) begin
      in_valid  = (($urandom % 100) < pin);
      in_word   = mem[wi];
      out_ready = (($urandom % 100) < pout);
      #1;
      if (prev_hold)
        check(out_valid && out_pixel == prev_pix, "R6 stalled pixel", 64'(out_pixel), 64'(prev_pix));
      if (out_valid)
        check(out_last == (pi == n - 1), "R8 last flag", 64'(out_last), 64'(pi == n - 1));
      if (in_ready && out_valid)
        check(out_ready && (pi % PW == PW - 1) && pi < n - 1, "R7 early accept", 64'(pi), 64'(PW - 1));
      if (out_valid && out_ready) begin
        check(out_pixel == exp_pix(pi), "R3/R5 pixel value", 64'(out_pixel), 64'(exp_pix(pi)));
        pi++;
      end
      if (in_valid && in_ready) wi++;
      prev_hold = out_valid && !out_ready;
      prev_pix  = out_pixel;
      @(negedge clk);
      cyc++;
    end
    if (abort_at < 0) begin
      check(pi == n, "R8 pixel count", 64'(pi), 64'(n));
      check(wi == (n + PW - 1) / PW, "R4 words consumed", 64'(wi), 64'((n + PW - 1) / PW));
      in_valid = 1'b1; out_ready = 1'b1;
      for (int k = 0; k < 4; k++) begin
        #1;
        check(!in_ready && !out_valid, "R8/R10 idle after frame", 64'({in_ready, out_valid}), 64'd0);
        @(negedge clk);
      end
    end
    in_valid = 1'b0; out_ready = 1'b0;
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; frame_start = 1'b0; frame_pixels = '0;
    in_valid = 1'b0; in_word = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && !out_last && !in_ready, "R1 in reset", 64'({out_valid, out_last, in_ready}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(!out_valid && !out_last && !in_ready, "R1 after reset", 64'({out_valid, out_last, in_ready}), 64'd0);

    run_frame(10, 100, 100, -1);   // R3 R5 full rate, back-to-back words
    run_frame(1, 100, 100, -1);    // R8 single pixel, second slot dropped
    run_frame(2, 100, 100, -1);    // R4 exactly one word
    run_frame(7, 50, 50, -1);      // R8 odd count drops top slot of last word
    run_frame(9, 100, 30, -1);     // R6 heavy backpressure
    run_frame(20, 70, 70, 5);      // R9 abort mid-frame
    run_frame(6, 80, 80, -1);      // R9 restart begins at slot 0 of new word
    run_frame(0, 100, 100, -1);    // R10 empty frame
    for (int f = 0; f < 8; f++)
      run_frame(int'($urandom % 60) + 1, 20 + int'($urandom % 80), 20 + int'($urandom % 80), -1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule